// File: doc/BRIEF.md
# DDR Burst Column Address Sequencer

This block generates the column address of every beat of one read or write burst for a DDR-style memory controller or memory model. A request carries a start column and a read/write flag. The block then issues one column per clock for the programmed number of beats. The beats follow either an up-counting order or an XOR order, and they never leave the aligned group of columns selected by the upper start-column bits.

A load-mode front end takes a mode word and captures three settings from it: the burst length code, the burst type bit and the DLL-reset bit. Raising the DLL-reset bit starts a relock window. During that window, and until a later load-mode command clears the bit, read requests are refused and reported. Write requests are never blocked.

The controller is a two-state machine. The states are `S_IDLE` and `S_BURST`, and it has four transitions:
- `IDLE->BURST` when a request is accepted.
- `BURST->BURST` while beats remain, or when a new request is accepted on the last beat.
- `BURST->IDLE` on the last beat when no request is accepted.
- `IDLE->IDLE` when nothing is started, which includes a refused read.

Top module: `burst_col_seq`

## Requirements
- R1: After reset the burst length is 2, the type is sequential and there is no lockout. In that state `req_ready`=1, `beat_valid`=0, `read_refused`=0 and `mode_illegal`=0.
- R2: A load-mode command whose `mode_word[2:0]` is 3'b001, 3'b010 or 3'b011 sets the burst length L to 2, 4 or 8 respectively.
- R3: Any other value of `mode_word[2:0]` discards the whole command, so all three settings keep their previous values. `mode_illegal` is high for exactly the next cycle.
- R4: `mode_word[3]`=0 selects sequential order. In sequential order beat i uses offset (s+i) mod L, where s is the start offset (the low log2(L) bits of `req_col`).
- R5: `mode_word[3]`=1 selects interleaved order. In interleaved order beat i uses offset s XOR i.
- R6: Every beat carries the bits of `req_col` above the low log2(L) offset bits unchanged. Burst length 2 varies only bit 0, length 4 varies bits 1..0 and length 8 varies bits 2..0.
- R7: An accepted burst issues its L beats on `beat_valid` in L consecutive cycles, beginning the cycle after the accepting clock edge. `beat_done` is high on the last beat only. `beat_is_read` echoes the request flag.
- R8: `req_ready` is high only in `S_IDLE` or on the last beat of a burst. A request accepted on the last beat starts the next burst with no gap.
- R9: A load-mode command with `mode_word[8]`=1 starts a lockout. A read presented at any of the following LOCK_CYC (default 200) clock edges is refused: no beats are issued and `read_refused` is high for the next cycle. Writes are issued normally during the lockout.
- R10: Reads are refused until the window has expired and a later load-mode command has written `mode_word[8]`=0. The first read after both conditions hold is accepted.
- R11: When a load-mode command and a request share a clock edge, the request is handled with the settings and lockout state from before that command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_load | input | 1 | Load-mode command strobe |
| mode_word | input | 13 | Mode word: [2:0] length code, [3] type, [8] DLL reset |
| req_valid | input | 1 | Burst request |
| req_is_read | input | 1 | 1 = read, 0 = write |
| req_col | input | 9 | Start column of the burst |
| req_ready | output | 1 | A request is taken at this edge if valid |
| beat_valid | output | 1 | A beat column is presented |
| beat_col | output | 9 | Column address of the current beat |
| beat_is_read | output | 1 | Direction of the current burst |
| beat_done | output | 1 | Current beat is the last of the burst |
| read_refused | output | 1 | Pulse: a read was refused during lockout |
| mode_illegal | output | 1 | Pulse: a load-mode had an illegal length code |

## Verification
A load-mode command and a burst request can arrive on the same clock edge. The bench provokes this by presenting a DLL-reset command that also changes the length from 8 to 4, together with a read request. It then checks two things. The read must be accepted and must run all eight beats in the old order, because it was judged against the pre-command settings. The next read must be refused. A second case places a request on the last beat of a running burst, and the bench checks that the new burst's first column appears in the very next cycle.

// File: rtl/bcs_pkg.sv
package bcs_pkg;
    typedef enum logic {
        S_IDLE  = 1'b0,
        S_BURST = 1'b1
    } bcs_state_t;

    typedef struct packed {
        logic [1:0] lg_len;
        logic       interleave;
    } bcs_cfg_t;
endpackage

// File: rtl/bcs_mode_ctl.sv
module bcs_mode_ctl
    import bcs_pkg::*;
#(
    parameter int MODE_W   = 13,
    parameter int TYPE_BIT = 3,
    parameter int DLL_BIT  = 8,
    parameter int LOCK_CYC = 200
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [MODE_W-1:0] word,
    output bcs_cfg_t          cfg,
    output logic              locked,
    output logic              illegal
);
    localparam int CNT_W = $clog2(LOCK_CYC + 1);

    logic [CNT_W-1:0] relock_cnt;
    logic             dll_held;
    logic             code_ok;
    logic [1:0]       code_lg;

    always_comb begin
        code_ok = 1'b1;
        code_lg = 2'd1;
        unique case (word[2:0])
            3'b001:  code_lg = 2'd1;
            3'b010:  code_lg = 2'd2;
            3'b011:  code_lg = 2'd3;
            default: code_ok = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg.lg_len     <= 2'd1;
            cfg.interleave <= 1'b0;
            relock_cnt     <= '0;
            dll_held       <= 1'b0;
            illegal        <= 1'b0;
        end else begin
            illegal <= load && !code_ok;
            if (load && code_ok && word[DLL_BIT]) begin
                relock_cnt <= CNT_W'(LOCK_CYC);
            end else if (relock_cnt != '0) begin
                relock_cnt <= relock_cnt - 1'b1;
            end
            if (load && code_ok) begin
                cfg.lg_len     <= code_lg;
                cfg.interleave <= word[TYPE_BIT];
                dll_held       <= word[DLL_BIT];
            end
        end
    end

    assign locked = (relock_cnt != '0) || dll_held;
endmodule

// File: rtl/bcs_addr_gen.sv
module bcs_addr_gen #(
    parameter int COL_W = 9,
    parameter int OFF_W = 3
) (
    input  logic [COL_W-1:0] start_col,
    input  logic [OFF_W-1:0] beat_idx,
    input  logic [1:0]       lg_len,
    input  logic             interleave,
    output logic [COL_W-1:0] col
);
    logic [OFF_W-1:0] seq_off;
    logic [OFF_W-1:0] xor_off;
    logic [OFF_W-1:0] raw_off;

    assign seq_off = start_col[OFF_W-1:0] + beat_idx;
    assign xor_off = start_col[OFF_W-1:0] ^ beat_idx;
    assign raw_off = interleave ? xor_off : seq_off;

    for (genvar b = 0; b < OFF_W; b++) begin : g_off_bit
        assign col[b] = (b < int'(lg_len)) ? raw_off[b] : start_col[b];
    end

    assign col[COL_W-1:OFF_W] = start_col[COL_W-1:OFF_W];
endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
    import bcs_pkg::*;
#(
    parameter int COL_W    = 9,
    parameter int MODE_W   = 13,
    parameter int LOCK_CYC = 200
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_load,
    input  logic [MODE_W-1:0] mode_word,
    input  logic              req_valid,
    input  logic              req_is_read,
    input  logic [COL_W-1:0]  req_col,
    output logic              req_ready,
    output logic              beat_valid,
    output logic [COL_W-1:0]  beat_col,
    output logic              beat_is_read,
    output logic              beat_done,
    output logic              read_refused,
    output logic              mode_illegal
);
    localparam int OFF_W = 3;

    bcs_state_t       state, state_nxt;
    bcs_cfg_t         cfg;
    logic             locked;
    logic [COL_W-1:0] cur_col;
    logic [OFF_W-1:0] cur_idx;
    logic [OFF_W-1:0] cur_last_idx;
    logic [1:0]       cur_lg;
    logic             cur_intl;
    logic             cur_rd;
    logic             refused_q;
    logic             at_last;
    logic             take;
    logic             start_ok;
    logic [COL_W-1:0] gen_col;

    bcs_mode_ctl #(
        .MODE_W  (MODE_W),
        .TYPE_BIT(3),
        .DLL_BIT (8),
        .LOCK_CYC(LOCK_CYC)
    ) u_mode (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (mode_load),
        .word   (mode_word),
        .cfg    (cfg),
        .locked (locked),
        .illegal(mode_illegal)
    );

    bcs_addr_gen #(
        .COL_W(COL_W),
        .OFF_W(OFF_W)
    ) u_addr (
        .start_col (cur_col),
        .beat_idx  (cur_idx),
        .lg_len    (cur_lg),
        .interleave(cur_intl),
        .col       (gen_col)
    );

    assign cur_last_idx = OFF_W'((1 << cur_lg) - 1);
    assign at_last      = (state == S_BURST) && (cur_idx == cur_last_idx);
    assign req_ready    = (state == S_IDLE) || at_last;
    assign take         = req_valid && req_ready;
    assign start_ok     = take && !(req_is_read && locked);

    always_comb begin
        state_nxt = state;
        unique case (state)
            S_IDLE:  state_nxt = start_ok ? S_BURST : S_IDLE;
            S_BURST: begin
                if (at_last) state_nxt = start_ok ? S_BURST : S_IDLE;
                else         state_nxt = S_BURST;
            end
            default: state_nxt = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_col   <= '0;
            cur_idx   <= '0;
            cur_lg    <= 2'd1;
            cur_intl  <= 1'b0;
            cur_rd    <= 1'b0;
            refused_q <= 1'b0;
        end else begin
            refused_q <= take && req_is_read && locked;
            if (start_ok) begin
                cur_col  <= req_col;
                cur_idx  <= '0;
                cur_lg   <= cfg.lg_len;
                cur_intl <= cfg.interleave;
                cur_rd   <= req_is_read;
            end else if (state == S_BURST && !at_last) begin
                cur_idx <= cur_idx + 1'b1;
            end
        end
    end

    always_comb begin
        beat_valid   = (state == S_BURST);
        beat_done    = at_last;
        beat_col     = beat_valid ? gen_col : '0;
        beat_is_read = beat_valid && cur_rd;
        read_refused = refused_q;
    end
endmodule

// File: rtl/bcs_checker.sv
module bcs_checker #(
    parameter int COL_W = 9,
    parameter int OFF_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             mode_load,
    input logic             req_ready,
    input logic             beat_valid,
    input logic [COL_W-1:0] beat_col,
    input logic             beat_done,
    input logic             read_refused,
    input logic             mode_illegal
);
    p_done_in_beat_r7: assert property (@(posedge clk) disable iff (!rst_n)
        beat_done |-> beat_valid);

    p_beats_contiguous_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid && !beat_done) |=> beat_valid);

    p_ready_only_at_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid && !beat_done) |-> !req_ready);

    p_block_kept_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid && !beat_done) |=>
            (beat_col[COL_W-1:OFF_W] == $past(beat_col[COL_W-1:OFF_W])));

    p_refuse_no_beat_r9: assert property (@(posedge clk) disable iff (!rst_n)
        read_refused |-> !beat_valid);

    p_illegal_after_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mode_illegal |-> $past(mode_load));
endmodule

bind burst_col_seq bcs_checker #(.COL_W(COL_W), .OFF_W(3)) u_bcs_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_load   (mode_load),
    .req_ready   (req_ready),
    .beat_valid  (beat_valid),
    .beat_col    (beat_col),
    .beat_done   (beat_done),
    .read_refused(read_refused),
    .mode_illegal(mode_illegal)
);

// File: tb/test_burst_col_seq.sv
`timescale 1ns/1ps
module test_burst_col_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_load = 1'b0;
    logic [12:0] mode_word = '0;
    logic        req_valid = 1'b0;
    logic        req_is_read = 1'b0;
    logic [8:0]  req_col = '0;
    logic        req_ready, beat_valid, beat_is_read, beat_done;
    logic        read_refused, mode_illegal;
    logic [8:0]  beat_col;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    burst_col_seq i_burst_col_seq (
        .clk(clk), .rst_n(rst_n), .mode_load(mode_load), .mode_word(mode_word),
        .req_valid(req_valid), .req_is_read(req_is_read), .req_col(req_col),
        .req_ready(req_ready), .beat_valid(beat_valid), .beat_col(beat_col),
        .beat_is_read(beat_is_read), .beat_done(beat_done),
        .read_refused(read_refused), .mode_illegal(mode_illegal)
    );

    // {len code[3], type, start col[9], offsets beat0..7 (3 bits each, beat0 first)}
    localparam logic [36:0] VEC [8] = '{
        {3'b001, 1'b0, 9'h0A1, 3'd1, 3'd0, 18'd0},
        {3'b010, 1'b0, 9'h1F6, 3'd2, 3'd3, 3'd0, 3'd1, 12'd0},
        {3'b010, 1'b1, 9'h035, 3'd1, 3'd0, 3'd3, 3'd2, 12'd0},
        {3'b011, 1'b0, 9'h12D, 3'd5, 3'd6, 3'd7, 3'd0, 3'd1, 3'd2, 3'd3, 3'd4},
        {3'b011, 1'b1, 9'h0FD, 3'd5, 3'd4, 3'd7, 3'd6, 3'd1, 3'd0, 3'd3, 3'd2},
        {3'b011, 1'b1, 9'h1C3, 3'd3, 3'd2, 3'd1, 3'd0, 3'd7, 3'd6, 3'd5, 3'd4},
        {3'b001, 1'b1, 9'h107, 3'd1, 3'd0, 18'd0},
        {3'b011, 1'b0, 9'h000, 3'd0, 3'd1, 3'd2, 3'd3, 3'd4, 3'd5, 3'd6, 3'd7}
    };

    task automatic tick;
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    function automatic logic [12:0] mword(input bit dll, input bit typ, input logic [2:0] code);
        return {4'b0, dll, 4'b0, typ, code};
    endfunction

    task automatic load_mode(input logic [12:0] w);
        mode_load = 1'b1;
        mode_word = w;
        tick();
        mode_load = 1'b0;
    endtask

    // run a burst and check each beat; seq gives offsets beat0 first
    task automatic run_burst(input logic [8:0] col, input bit rd, input int len,
                             input logic [23:0] seq, input string tag);
        logic [8:0] mask;
        mask = 9'(len - 1);
        req_valid = 1'b1; req_is_read = rd; req_col = col;
        chk(req_ready, {tag, " R8 ready before start"}, req_ready, 1);
        tick();
        req_valid = 1'b0;
        for (int i = 0; i < len; i++) begin
            logic [8:0] exp;
            exp = (col & ~mask) | 9'(seq[23-3*i -: 3]);
            chk(beat_valid, {tag, " R7 beat valid"}, beat_valid, 1);
            chk(beat_col == exp, {tag, " R4/R5/R6 beat col"}, beat_col, exp);
            chk(beat_done == (i == len - 1), {tag, " R7 done flag"}, beat_done, i == len - 1);
            chk(beat_is_read == rd, {tag, " R7 direction"}, beat_is_read, rd);
            tick();
        end
        chk(!beat_valid, {tag, " R7 idle after burst"}, beat_valid, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            n_run++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R1: reset state, then default length 2 sequential, no lockout
        chk(req_ready, "R1 ready", req_ready, 1);
        chk(!beat_valid, "R1 no beat", beat_valid, 0);
        chk(!read_refused, "R1 no refusal", read_refused, 0);
        chk(!mode_illegal, "R1 no illegal", mode_illegal, 0);
        run_burst(9'h0C1, 1'b1, 2, {3'd1, 3'd0, 18'd0}, "R1 default read");

        // table walk: R2 length codes, R4 sequential, R5 interleaved, R6 block
        for (int v = 0; v < 8; v++) begin
            logic [36:0] e;
            int len;
            e = VEC[v];
            len = 1 << int'(e[35:34]);
            load_mode(mword(1'b0, e[33], e[36:34]));
            run_burst(e[32:24], v[0], len, e[23:0], $sformatf("R2 vec%0d", v));
        end

        // R3: illegal codes leave previous settings (len 8 sequential)
        load_mode(mword(1'b0, 1'b1, 3'b101));
        chk(mode_illegal, "R3 illegal pulse", mode_illegal, 1);
        tick();
        chk(!mode_illegal, "R3 pulse single", mode_illegal, 0);
        load_mode(mword(1'b1, 1'b1, 3'b000));
        chk(mode_illegal, "R3 illegal pulse code0", mode_illegal, 1);
        run_burst(9'h12D, 1'b1, 8, {3'd5, 3'd6, 3'd7, 3'd0, 3'd1, 3'd2, 3'd3, 3'd4}, "R3 kept");

        // R8: back-to-back, len 4 sequential
        load_mode(mword(1'b0, 1'b0, 3'b010));
        req_valid = 1'b1; req_is_read = 1'b0; req_col = 9'h010;
        tick();
        req_col = 9'h023;
        for (int i = 0; i < 3; i++) begin
            chk(!req_ready, "R8 busy mid burst", req_ready, 0);
            tick();
        end
        chk(req_ready && beat_done, "R8 ready on last", req_ready, 1);
        tick();
        req_valid = 1'b0;
        chk(beat_valid && beat_col == 9'h023, "R8 no gap", beat_col, 9'h023);
        repeat (4) tick();
        chk(!beat_valid, "R8 second ends", beat_valid, 0);

        // R11: load-mode (DLL reset, len 4) with a read in the same cycle; len 8 first
        load_mode(mword(1'b0, 1'b0, 3'b011));
        mode_load = 1'b1; mode_word = mword(1'b1, 1'b0, 3'b010);
        req_valid = 1'b1; req_is_read = 1'b1; req_col = 9'h12D;
        tick();
        mode_load = 1'b0; req_valid = 1'b0;
        for (int i = 0; i < 8; i++) begin
            logic [8:0] exp;
            exp = 9'h128 | 9'((5 + i) % 8);
            chk(beat_valid && beat_col == exp, "R11 old settings", beat_col, exp);
            tick();
        end
        chk(!beat_valid, "R11 len8 ended", beat_valid, 0);
        // R9: read refused, write allowed (new length 4)
        req_valid = 1'b1; req_is_read = 1'b1; req_col = 9'h040;
        tick();
        req_valid = 1'b0;
        chk(read_refused, "R9 read refused", read_refused, 1);
        chk(!beat_valid, "R9 no beats", beat_valid, 0);
        run_burst(9'h046, 1'b0, 4, {3'd2, 3'd3, 3'd0, 3'd1, 12'd0}, "R9 write in lockout");

        // R10: window over but not cleared -> still refused
        repeat (210) tick();
        req_valid = 1'b1; req_is_read = 1'b1; req_col = 9'h040;
        tick();
        req_valid = 1'b0;
        chk(read_refused, "R10 uncleared refused", read_refused, 1);
        load_mode(mword(1'b0, 1'b0, 3'b010));
        run_burst(9'h041, 1'b1, 4, {3'd1, 3'd2, 3'd3, 3'd0, 12'd0}, "R10 cleared read");

        // R9/R10 window edge: reset at E0, clear at E0+1
        load_mode(mword(1'b1, 1'b0, 3'b011));
        load_mode(mword(1'b0, 1'b0, 3'b011));
        req_valid = 1'b1; req_is_read = 1'b1; req_col = 9'h000;
        tick();
        req_valid = 1'b0;
        chk(read_refused, "R9 early read refused", read_refused, 1);
        repeat (197) tick();
        req_valid = 1'b1;
        tick();
        chk(read_refused && !beat_valid, "R9 read at last locked edge", read_refused, 1);
        tick();
        req_valid = 1'b0;
        chk(!read_refused && beat_valid && beat_col == 9'h000, "R10 first read accepted",
            beat_col, 0);
        repeat (8) tick();
        chk(!beat_valid, "R10 burst ended", beat_valid, 0);

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule